// File: doc/BRIEF.md
# UART Status Flag and Interrupt Unit

This block keeps the ten status flags of a serial port, transmit side and receive side, and folds them into three interrupt request lines: one for transmit, one for receive and one for errors. The serial engines report each condition as a one-cycle set pulse. The bus decode reports accesses as two strobes, one for a read of the status register and one for a read of the data register. Each flag has its own enable bit. The enable bits steer only the request lines, so software can also poll the flags with all interrupts off.

A flag is cleared in two steps. Software first reads the status register while the flag is set. A later data-register read then clears it. The status read only marks the flags that were set at that moment, so a condition that arrives between the two reads is not lost. The idle flag has one more rule: once it has been cleared it stays quiet, whatever the line does, until a new character has arrived and the receive-full flag has set.

Top module: `uart_flag_irq`

## Requirements
- R1: After reset, every flag and all three request outputs are 0.
- R2: A pulse on `set_evt[i]` makes `flags[i]` read 1 from the next clock edge. The flag stays 1 until it is cleared. Bit order is: 0 transmit-empty, 1 transmit-complete, 2 receive-full, 3 idle, 4 receive-edge, 5 break-detect, 6 overrun, 7 noise, 8 framing, 9 parity.
- R3: A flag clears on the edge of a `data_rd` pulse only if a `stat_rd` pulse came earlier while that flag was set. A `data_rd` with no such earlier status read leaves every flag unchanged. Each `data_rd` uses up the marks, so a second `data_rd` clears nothing.
- R4: A flag that sets after the status read and before the data read stays set after the data read.
- R5: When a set pulse and a clearing data read hit the same flag in the same cycle, the flag stays 1.
- R6: Once the idle flag (bit 3) has been cleared, idle set pulses are ignored until a receive-full (bit 2) set pulse has been seen. Idle pulses in the cycles after that pulse set the flag again.
- R7: `irq_tx` is a registered level. It goes to 1 one cycle after flag 0 or flag 1 is 1 with its enable bit set, and it stays 1 while that condition holds.
- R8: `irq_rx` behaves the same way for flags 2 to 5.
- R9: `irq_err` behaves the same way for flags 6 to 9.
- R10: Enable bits have no effect on the flags. With an enable at 0, its flag still sets and reads back, and it does not drive a request line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_evt | input | 10 | One-cycle set pulses from the serial engines |
| irq_en | input | 10 | Per-flag interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| flags | output | 10 | Current flag values for polling |
| irq_tx | output | 1 | Transmit group request |
| irq_rx | output | 1 | Receive group request |
| irq_err | output | 1 | Error group request |

## Verification
The bench issues a data read without a prior status read. A design that clears on the data read alone would lose flags there. It sets a second flag between the two reads, which catches a design that clears every flag rather than only the marked ones. It also drives a set pulse in the same cycle as the clearing read, which catches a design that gives the clear priority. For the idle flag, the bench sends idle pulses both before and after a receive-full pulse. A design without the lock would set the flag again at once, and a design that never releases the lock would keep it clear for good. Finally, each request line is checked with its enables off and then on, which shows whether the flags are routed to the wrong group or gated by the enables.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int NUM_FLAGS  = 10;
  localparam int NUM_GROUPS = 3;

  localparam int F_TX_EMPTY = 0;
  localparam int F_TX_DONE  = 1;
  localparam int F_RX_FULL  = 2;
  localparam int F_IDLE     = 3;
  localparam int F_RX_EDGE  = 4;
  localparam int F_BREAK    = 5;
  localparam int F_OVERRUN  = 6;
  localparam int F_NOISE    = 7;
  localparam int F_FRAMING  = 8;
  localparam int F_PARITY   = 9;

  localparam logic [NUM_FLAGS-1:0] MASK_TX  = 10'b00_0000_0011;
  localparam logic [NUM_FLAGS-1:0] MASK_RX  = 10'b00_0011_1100;
  localparam logic [NUM_FLAGS-1:0] MASK_ERR = 10'b11_1100_0000;

  function automatic logic [NUM_FLAGS-1:0] group_mask(input int g);
    case (g)
      0:       return MASK_TX;
      1:       return MASK_RX;
      default: return MASK_ERR;
    endcase
  endfunction
endpackage

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         stat_rd,
  input  logic         data_rd,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] cleared_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] arm_q;
  logic [N-1:0] clr;

  assign clr       = data_rd ? arm_q : '0;
  assign cleared_o = clr & flag_q & ~set_i;
  assign flag_o    = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set_i;
      if (stat_rd)
        arm_q <= flag_q & ~clr;
      else if (data_rd)
        arm_q <= '0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2 / R5: a set pulse always leaves the flag at 1
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]);
    // R3: a flag only falls on a data read
    p_fall_on_read_r3: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !data_rd) |=> flag_q[i]);
  end
endmodule

// File: rtl/uart_idle_guard.sv
module uart_idle_guard (
  input  logic clk,
  input  logic rst,
  input  logic idle_req,
  input  logic rx_full_set,
  input  logic idle_cleared,
  output logic idle_ok
);
  logic lock_q;

  assign idle_ok = idle_req & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= 1'b0;
    else if (rx_full_set)
      lock_q <= 1'b0;
    else if (idle_cleared)
      lock_q <= 1'b1;
  end

  // R6: a clear with no new character leaves the guard closed
  p_lock_after_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (idle_cleared && !rx_full_set) |=> lock_q);
endmodule

// File: rtl/uart_irq_group.sv
module uart_irq_group #(
  parameter int             N    = 10,
  parameter logic [N-1:0]   MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_i & en_i & MASK);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
  import uart_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_evt,
  input  logic [NUM_FLAGS-1:0] irq_en,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_err
);
  logic [NUM_FLAGS-1:0]  set_eff;
  logic [NUM_FLAGS-1:0]  cleared;
  logic [NUM_GROUPS-1:0] irq_vec;
  logic                  idle_ok;

  uart_idle_guard u_idle (
    .clk          (clk),
    .rst          (rst),
    .idle_req     (set_evt[F_IDLE]),
    .rx_full_set  (set_evt[F_RX_FULL]),
    .idle_cleared (cleared[F_IDLE]),
    .idle_ok      (idle_ok)
  );

  always_comb begin
    set_eff         = set_evt;
    set_eff[F_IDLE] = idle_ok;
  end

  uart_flag_bank #(.N(NUM_FLAGS)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_eff),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .flag_o    (flags),
    .cleared_o (cleared)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq
    uart_irq_group #(.N(NUM_FLAGS), .MASK(group_mask(g))) u_grp (
      .clk   (clk),
      .rst   (rst),
      .flag_i(flags),
      .en_i  (irq_en),
      .irq_o (irq_vec[g])
    );
  end

  assign irq_tx  = irq_vec[0];
  assign irq_rx  = irq_vec[1];
  assign irq_err = irq_vec[2];

  // R7: an enabled transmit flag raises the transmit line a cycle later
  p_tx_level_r7: assert property (@(posedge clk) disable iff (rst)
    ((flags[F_TX_EMPTY] && irq_en[F_TX_EMPTY]) || (flags[F_TX_DONE] && irq_en[F_TX_DONE])) |=> irq_tx);
  // R9: no error request without an error flag one cycle earlier
  p_err_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(|(flags & MASK_ERR)));
  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (flags == '0 && !irq_tx && !irq_rx && !irq_err));
  // R10: an enable change alone never alters the flags
  p_en_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (set_eff == '0 && !data_rd) |=> $stable(flags));
endmodule

// File: tb/uart_flag_irq_test.sv
module uart_flag_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] set_evt = '0;
  logic [9:0] irq_en = '0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [9:0] flags;
  logic       irq_tx, irq_rx, irq_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_flag_irq uut (
    .clk(clk), .rst(rst), .set_evt(set_evt), .irq_en(irq_en),
    .stat_rd(stat_rd), .data_rd(data_rd), .flags(flags),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_set(input logic [9:0] m);
    set_evt = m; @(negedge clk); set_evt = '0;
  endtask
  task automatic pulse_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask
  task automatic pulse_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
  endtask
  task automatic clear_all();
    pulse_stat(); pulse_data(); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 10'h000);
    chk("R1 irqs", {7'd0, irq_tx, irq_rx, irq_err}, 10'h000);
  endtask

  task automatic t_set_hold();
    pulse_set(10'b00_0000_0001);
    chk("R2 set", flags, 10'b00_0000_0001);
    repeat (3) @(negedge clk);
    chk("R2 hold", flags, 10'b00_0000_0001);
    pulse_data();
    chk("R3 data read alone", flags, 10'b00_0000_0001);
    clear_all();
  endtask

  task automatic t_clear_seq();
    pulse_set(10'b00_0010_0000);
    pulse_stat();
    @(negedge clk);
    chk("R3 after status read", flags, 10'b00_0010_0000);
    pulse_data();
    chk("R3 cleared", flags, 10'h000);
    pulse_set(10'b00_0010_0000);
    pulse_data();
    chk("R3 marks used up", flags, 10'b00_0010_0000);
    clear_all();
  endtask

  task automatic t_between();
    pulse_set(10'b00_0100_0000);
    pulse_stat();
    pulse_set(10'b00_1000_0000);
    pulse_data();
    chk("R4 late flag kept", flags, 10'b00_1000_0000);
    clear_all();
    chk("R4 second sequence", flags, 10'h000);
  endtask

  task automatic t_same_cycle();
    pulse_set(10'b01_0000_0000);
    pulse_stat();
    set_evt = 10'b01_0000_0000; data_rd = 1'b1;
    @(negedge clk);
    set_evt = '0; data_rd = 1'b0;
    chk("R5 set wins", flags, 10'b01_0000_0000);
    clear_all();
  endtask

  task automatic t_idle();
    pulse_set(10'b00_0000_1000);
    chk("R6 idle sets", flags, 10'b00_0000_1000);
    clear_all();
    pulse_set(10'b00_0000_1000);
    chk("R6 idle locked", flags, 10'h000);
    pulse_set(10'b00_0000_0100);
    pulse_set(10'b00_0000_1000);
    chk("R6 idle re-armed", flags, 10'b00_0000_1100);
    clear_all();
  endtask

  task automatic t_irq();
    irq_en = '0;
    pulse_set(10'b10_0001_0010);
    @(negedge clk);
    chk("R10 flags with enables off", flags, 10'b10_0001_0010);
    chk("R10 no request", {7'd0, irq_tx, irq_rx, irq_err}, 10'h000);
    irq_en = 10'b00_0000_0010;
    @(negedge clk);
    chk("R7 tx only", {7'd0, irq_tx, irq_rx, irq_err}, 10'b100);
    irq_en = 10'b00_0001_0000;
    @(negedge clk);
    chk("R8 rx only", {7'd0, irq_tx, irq_rx, irq_err}, 10'b010);
    irq_en = 10'b10_0000_0000;
    @(negedge clk);
    chk("R9 err only", {7'd0, irq_tx, irq_rx, irq_err}, 10'b001);
    irq_en = 10'h3FF;
    @(negedge clk);
    chk("R7 all groups", {7'd0, irq_tx, irq_rx, irq_err}, 10'b111);
    clear_all();
    chk("R9 drop after clear", {7'd0, irq_tx, irq_rx, irq_err}, 10'h000);
    irq_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_hold();
    t_clear_seq();
    t_between();
    t_same_cycle();
    t_idle();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule